// File: doc/BRIEF.md
# SDRAM Byte-Lane Data Mask Unit

This block is the data-side masking stage of a 16-bit synchronous DRAM device model. It sits between the data pins and a small internal storage array. Two mask inputs, one per byte lane, decide for each data beat whether a byte is stored on a write or driven on a read. The same two mask pins serve both directions, but they take effect with different timing. On a write the mask applies to the beat on the same clock edge. On a read it applies to the beat that leaves the output register two edges later.

A burst is started by a one-cycle start pulse that carries a 4-bit start address. Every burst is four beats long. Reads and writes each have their own sequencer, so both directions can run at the same time. Tri-state is modelled by a per-lane output enable next to the output data. A masked read beat still uses its slot in the burst, and only its drivers are switched off.

Top module: `lm_lane_mask`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `dq_oe` is 2'b00 and `dq_out` is zero.
- R2: On a write beat with `lane_mask[l]` low, byte lane l of `wr_data` is stored at that beat's address. Lane 1 is bits 15..8 and lane 0 is bits 7..0. The mask value used is the one sampled on the same edge as the data.
- R3: On a write beat with `lane_mask[l]` high, byte lane l at that address keeps its previous value. The other lane is unaffected.
- R4: A burst started by a start pulse at edge n has exactly four beats, at edges n to n+3. Beat k uses the address `{a[3:2], (a[1:0]+k) mod 4}`, where a is the start address, so the address wraps inside its aligned group of four.
- R5: For a read started at edge n, beat k is presented after edge n+2+k: `dq_out` carries the stored word, and `dq_oe` is high for every lane whose mask allows it.
- R6: The `lane_mask` value sampled at edge m controls the read output registered at edge m+2. A masked lane has its `dq_oe` bit low and its `dq_out` byte zero.
- R7: A masked read beat still uses its slot. The beats that follow keep their own addresses and output cycles.
- R8: When no read beat is being presented, `dq_oe` is 2'b00 whatever the mask inputs are.
- R9: A start pulse that arrives during an ongoing burst of the same direction abandons the rest of that burst and begins a new four-beat burst from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Pulse that begins a four-beat read burst |
| rd_addr | input | 4 | Start address of the read burst |
| wr_start | input | 1 | Pulse that begins a four-beat write burst; beat 0 is this cycle |
| wr_addr | input | 4 | Start address of the write burst |
| wr_data | input | 16 | Write data for the current write beat |
| lane_mask | input | 2 | Byte-lane masks: bit 1 masks bits 15..8, bit 0 masks bits 7..0 |
| dq_out | output | 16 | Read data; a byte whose lane is disabled reads zero |
| dq_oe | output | 2 | Per-lane output enable (low means high impedance) |

## Verification
Each result has its own due cycle. A write store takes effect on the edge of the write beat itself, so it is observed through a later read. A read beat started at edge n appears on the outputs after edge n+2+k, and a mask sampled at edge m shapes the output registered at edge m+2. The bench reference model advances on each rising edge with its own queues of burst addresses and a two-deep history of mask values. It compares both outputs at every falling edge, so every expected value is checked exactly in the cycle the requirements place it.

// File: rtl/lm_lane_mask_pkg.sv
package lm_lane_mask_pkg;
  // Default geometry of the data path
  localparam int LM_LANE_W = 8;
  localparam int LM_LANES  = 2;
  localparam int LM_ADDR_W = 4;
  localparam int LM_BURST  = 4;
  localparam int LM_RD_LAT = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } lm_seq_state_e;
endpackage

// File: rtl/lm_burst_seq.sv
module lm_burst_seq
  import lm_lane_mask_pkg::*;
#(
  parameter int ADDR_W = LM_ADDR_W,
  parameter int BURST  = LM_BURST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              beat_vld,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int BEAT_W = (BURST > 1) ? $clog2(BURST) : 1;

  lm_seq_state_e     state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] idx_q, idx_d;
  logic [BEAT_W-1:0] off;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (start) begin
      state_d = SEQ_RUN;
      idx_d   = BEAT_W'(1);
    end else if (state_q == SEQ_RUN) begin
      idx_d = idx_q + BEAT_W'(1);
      if (idx_q == BEAT_W'(BURST - 1)) begin
        state_d = SEQ_IDLE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (start) begin
        base_q <= start_addr;
      end
    end
  end

  // current beat: start cycle is beat 0, wrap inside aligned group
  assign off      = base_q[BEAT_W-1:0] + idx_q;
  assign beat_vld = start | (state_q == SEQ_RUN);
  assign beat_addr = start ? start_addr : {base_q[ADDR_W-1:BEAT_W], off};
endmodule

// File: rtl/lm_mask_pipe.sv
module lm_mask_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_in,
  output logic mask_dly
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], mask_in};
  end

  // resets to the masked (high impedance) state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign mask_dly = sh_q[STAGES-1];
endmodule

// File: rtl/lm_byte_regfile.sv
module lm_byte_regfile #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[l]) begin
        mem_q[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      end
    end

    assign rd_data[l*LANE_W +: LANE_W] = mem_q[rd_addr];
  end
endmodule

// File: rtl/lm_lane_mask.sv
module lm_lane_mask
  import lm_lane_mask_pkg::*;
#(
  parameter int LANE_W = LM_LANE_W,
  parameter int LANES  = LM_LANES,
  parameter int ADDR_W = LM_ADDR_W,
  parameter int BURST  = LM_BURST,
  parameter int RD_LAT = LM_RD_LAT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_start,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     wr_start,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [LANES-1:0]         lane_mask,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic [LANES-1:0]         dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  // write side: mask applies on the same edge
  logic              wr_vld;
  logic [ADDR_W-1:0] wr_beat_addr;
  logic [LANES-1:0]  lane_we;

  // read side
  logic              rd_vld;
  logic [ADDR_W-1:0] rd_beat_addr;
  logic              fetch_vld_q;
  logic [ADDR_W-1:0] fetch_addr_q;
  logic              data_vld_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rf_rd_data;
  logic [LANES-1:0]  mask_dly;

  logic [LANES-1:0]  oe_d, dq_oe_q;
  logic [DATA_W-1:0] dq_d, dq_out_q;

  lm_burst_seq #(.ADDR_W(ADDR_W), .BURST(BURST)) u_wr_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (wr_start),
    .start_addr(wr_addr),
    .beat_vld  (wr_vld),
    .beat_addr (wr_beat_addr)
  );

  lm_burst_seq #(.ADDR_W(ADDR_W), .BURST(BURST)) u_rd_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_start),
    .start_addr(rd_addr),
    .beat_vld  (rd_vld),
    .beat_addr (rd_beat_addr)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_we[l] = wr_vld & ~lane_mask[l];
    end
  end

  lm_byte_regfile #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_rf (
    .clk    (clk),
    .wr_en  (lane_we),
    .wr_addr(wr_beat_addr),
    .wr_data(wr_data),
    .rd_addr(fetch_addr_q),
    .rd_data(rf_rd_data)
  );

  // read mask delay, one pipe per lane
  for (genvar l = 0; l < LANES; l++) begin : g_mask
    lm_mask_pipe #(.STAGES(RD_LAT)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_in (lane_mask[l]),
      .mask_dly(mask_dly[l])
    );
  end

  // read fetch and data stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_vld_q  <= 1'b0;
      fetch_addr_q <= '0;
      data_vld_q   <= 1'b0;
      data_q       <= '0;
    end else begin
      fetch_vld_q <= rd_vld;
      data_vld_q  <= fetch_vld_q;
      if (rd_vld) begin
        fetch_addr_q <= rd_beat_addr;
      end
      if (fetch_vld_q) begin
        data_q <= rf_rd_data;
      end
    end
  end

  // output enable and gated data
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      oe_d[l] = data_vld_q & ~mask_dly[l];
      dq_d[l*LANE_W +: LANE_W] = oe_d[l] ? data_q[l*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe_q  <= '0;
      dq_out_q <= '0;
    end else begin
      dq_oe_q  <= oe_d;
      dq_out_q <= dq_d;
    end
  end

  assign dq_oe  = dq_oe_q;
  assign dq_out = dq_out_q;
endmodule

// File: rtl/lm_lane_mask_chk.sv
module lm_lane_mask_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int ADDR_W = 4,
  parameter int BEAT_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_start,
  input logic                     wr_start,
  input logic [LANES-1:0]         lane_mask,
  input logic [LANES-1:0]         dq_oe,
  input logic [LANES*LANE_W-1:0]  dq_out,
  input logic                     wr_vld,
  input logic [ADDR_W-1:0]        wr_beat_addr
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // mask sampled three sampling points earlier gates this output
    assert_read_mask_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[l] |-> !$past(lane_mask[l], 3));

    assert_masked_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[l] |-> (dq_out[l*LANE_W +: LANE_W] == '0));
  end

  assert_oe_needs_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> ($past(rd_start, 3) || $past(rd_start, 4) ||
                  $past(rd_start, 5) || $past(rd_start, 6)));

  assert_wr_beats_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && !wr_start) |-> $past(wr_vld));

  assert_wr_group_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && !wr_start) |->
      (wr_beat_addr[ADDR_W-1:BEAT_W] == $past(wr_beat_addr[ADDR_W-1:BEAT_W])));
endmodule

bind lm_lane_mask lm_lane_mask_chk #(
  .LANE_W(LANE_W),
  .LANES (LANES),
  .ADDR_W(ADDR_W),
  .BEAT_W($clog2(BURST))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_start    (rd_start),
  .wr_start    (wr_start),
  .lane_mask   (lane_mask),
  .dq_oe       (dq_oe),
  .dq_out      (dq_out),
  .wr_vld      (wr_vld),
  .wr_beat_addr(wr_beat_addr)
);

// File: tb/lm_lane_mask_bench.sv
module lm_lane_mask_bench;
  logic        clk;
  logic        rst_n;
  logic        rd_start;
  logic [3:0]  rd_addr;
  logic        wr_start;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  lane_mask;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;

  int    checks = 0;
  int    failures = 0;
  int    cyc_cnt = 0;
  bit    done = 0;
  bit    cmp_en = 0;
  string cur_tag = "R1";
  int    seed_idx = 0;

  lm_lane_mask u_lm_lane_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .rd_addr  (rd_addr),
    .wr_start (wr_start),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .lane_mask(lane_mask),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_mem [16];
  int          rq[$];
  int          wq[$];
  logic        iss_v;
  int          iss_a;
  logic        f_v;
  logic [15:0] f_d;
  logic [1:0]  mh1, mh2;
  logic [1:0]  exp_oe;
  logic [15:0] exp_dq;

  function automatic int grp_addr(input int a, input int k);
    return (a & ~3) | ((a + k) & 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq.delete();
      wq.delete();
      iss_v  = 1'b0;
      iss_a  = 0;
      f_v    = 1'b0;
      f_d    = '0;
      mh1    = 2'b11;
      mh2    = 2'b11;
      exp_oe = 2'b00;
      exp_dq = '0;
    end else begin
      // output registered now: fetched beat gated by mask two edges old
      for (int l = 0; l < 2; l++) begin
        exp_oe[l] = f_v & ~mh2[l];
        exp_dq[l*8 +: 8] = exp_oe[l] ? f_d[l*8 +: 8] : 8'h00;
      end
      mh2 = mh1;
      mh1 = lane_mask;
      // fetch of beat issued last edge, before this edge's write
      f_v = iss_v;
      f_d = iss_v ? m_mem[iss_a] : f_d;
      // read issue (R4, R9)
      if (rd_start) begin
        rq.delete();
        for (int k = 0; k < 4; k++) rq.push_back(grp_addr(int'(rd_addr), k));
      end
      if (rq.size() > 0) begin
        iss_v = 1'b1;
        iss_a = rq.pop_front();
      end else begin
        iss_v = 1'b0;
      end
      // write beat with zero-latency mask (R2, R3)
      if (wr_start) begin
        wq.delete();
        for (int k = 0; k < 4; k++) wq.push_back(grp_addr(int'(wr_addr), k));
      end
      if (wq.size() > 0) begin
        int a;
        a = wq.pop_front();
        for (int l = 0; l < 2; l++) begin
          if (!lane_mask[l]) m_mem[a][l*8 +: 8] = wr_data[l*8 +: 8];
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      checks++;
      if (dq_oe !== exp_oe || dq_out !== exp_dq) begin
        failures++;
        $display("FAIL %s cycle %0d: oe=%b dq=%h expected oe=%b dq=%h",
                 cur_tag, cyc_cnt, dq_oe, dq_out, exp_oe, exp_dq);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected under 20000", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input logic rs, input logic [3:0] ra,
                     input logic ws, input logic [3:0] wa,
                     input logic [1:0] m, input string tag);
    @(negedge clk);
    #0;
    cur_tag   = tag;
    rd_start  = rs;
    rd_addr   = ra;
    wr_start  = ws;
    wr_addr   = wa;
    lane_mask = m;
    seed_idx++;
    wr_data   = 16'h3C5A ^ 16'(seed_idx * 16'h1357);
  endtask

  task automatic idle(input int n, input logic [1:0] m, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 1'b0, 4'h0, m, tag);
  endtask

  task automatic wr_burst(input logic [3:0] a, input logic [1:0] m0,
                          input logic [1:0] m1, input logic [1:0] m2,
                          input logic [1:0] m3, input string tag);
    cyc(1'b0, 4'h0, 1'b1, a, m0, tag);
    cyc(1'b0, 4'h0, 1'b0, 4'h0, m1, tag);
    cyc(1'b0, 4'h0, 1'b0, 4'h0, m2, tag);
    cyc(1'b0, 4'h0, 1'b0, 4'h0, m3, tag);
  endtask

  task automatic check_r1(input string when);
    checks++;
    if (dq_oe !== 2'b00 || dq_out !== 16'h0000) begin
      failures++;
      $display("FAIL R1 %s: oe=%b dq=%h expected oe=00 dq=0000", when, dq_oe, dq_out);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    rd_start = 1'b0; rd_addr = '0;
    wr_start = 1'b0; wr_addr = '0;
    wr_data = '0; lane_mask = 2'b00;
    repeat (3) @(negedge clk);
    check_r1("during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_r1("after release");
    cmp_en = 1'b1;

    // fill the whole array, no masking (R2)
    for (int b = 0; b < 4; b++) wr_burst(4'(b * 4), 2'b00, 2'b00, 2'b00, 2'b00, "R2");
    // no read beats: enables stay low for any mask (R8)
    idle(2, 2'b00, "R8"); idle(2, 2'b01, "R8"); idle(2, 2'b10, "R8"); idle(2, 2'b11, "R8");
    idle(3, 2'b00, "R8");
    // plain read, beat timing and data (R5)
    cyc(1'b1, 4'd0, 1'b0, 4'h0, 2'b00, "R5");
    idle(7, 2'b00, "R5");
    // wrapping addresses for read and write (R4)
    cyc(1'b1, 4'd6, 1'b0, 4'h0, 2'b00, "R4");
    idle(7, 2'b00, "R4");
    wr_burst(4'd14, 2'b00, 2'b00, 2'b00, 2'b00, "R4");
    cyc(1'b1, 4'd12, 1'b0, 4'h0, 2'b00, "R4");
    idle(7, 2'b00, "R4");
    // read mask changing per beat, masked beats keep their slots (R6, R7)
    cyc(1'b1, 4'd8, 1'b0, 4'h0, 2'b01, "R6/R7");
    cyc(1'b0, 4'd0, 1'b0, 4'h0, 2'b10, "R6/R7");
    cyc(1'b0, 4'd0, 1'b0, 4'h0, 2'b11, "R6/R7");
    cyc(1'b0, 4'd0, 1'b0, 4'h0, 2'b00, "R6/R7");
    idle(6, 2'b11, "R6/R7");
    cyc(1'b1, 4'd1, 1'b0, 4'h0, 2'b11, "R6/R7");
    cyc(1'b0, 4'd0, 1'b0, 4'h0, 2'b11, "R6/R7");
    cyc(1'b0, 4'd0, 1'b0, 4'h0, 2'b00, "R6/R7");
    idle(6, 2'b00, "R6/R7");
    // write masks, same-edge latency, previous byte held (R2, R3)
    wr_burst(4'd9, 2'b01, 2'b10, 2'b00, 2'b11, "R2/R3");
    cyc(1'b1, 4'd8, 1'b0, 4'h0, 2'b00, "R2/R3");
    idle(7, 2'b00, "R2/R3");
    // restart of bursts mid-way (R9)
    cyc(1'b0, 4'h0, 1'b1, 4'd0, 2'b00, "R9");
    cyc(1'b0, 4'h0, 1'b0, 4'd0, 2'b00, "R9");
    wr_burst(4'd5, 2'b00, 2'b10, 2'b00, 2'b01, "R9");
    cyc(1'b1, 4'd0, 1'b0, 4'h0, 2'b00, "R9");
    cyc(1'b0, 4'd0, 1'b0, 4'h0, 2'b00, "R9");
    cyc(1'b1, 4'd4, 1'b0, 4'h0, 2'b00, "R9");
    idle(8, 2'b00, "R9");
    // read and write together on the same group (R5)
    cyc(1'b1, 4'd4, 1'b1, 4'd4, 2'b00, "R5");
    idle(3, 2'b00, "R5");
    cyc(1'b1, 4'd4, 1'b0, 4'h0, 2'b00, "R5");
    cyc(1'b1, 4'd10, 1'b0, 4'h0, 2'b00, "R5/R9");
    idle(10, 2'b00, "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule